// File: doc/BRIEF.md
# Synchronous Serial Transmitter with Frame Check Sequence

This block sends bytes on a single serial line for character-synchronous and bit-synchronous links. Software-style control inputs set it up. A one-entry holding buffer accepts a byte on a write strobe. Each byte is moved into a shift register and sent least significant bit first, one bit for each pulse of a bit-clock enable. While the line is enabled and bytes keep arriving, they are sent back to back. A 16-bit check value is accumulated over the bytes chosen for inclusion.

When the buffer runs dry, the transmitter fills the line. It appends the check value if check sending is enabled at that moment. Otherwise it sends idle fill characters. The fill character is a programmable sync byte in character-synchronous mode and the flag pattern 0x7E in bit-synchronous mode. Turning the transmitter off lets a data or fill character finish. Turning it off during the check value cuts the check value short and sends one fill character in its place.

An active-low request-to-send output either follows its control bit or, in asynchronous auto-enable mode, stays asserted until the last character has left.

Top module: `sync_ser_tx`

## Requirements
- R1: While reset is applied: ser_out is 1, rts_n is 1 and buf_empty is 1.
- R2: While tx_enable is 0, ser_out holds 1 at every bit tick and a byte in the holding buffer stays there (buf_empty stays 0).
- R3: A byte is sent as 8 bits, least significant bit first, one bit per clock with bit_en high; ser_out does not change in a clock with bit_en low. Back-to-back bytes follow with no gap.
- R4: At underrun, with tx_crc_en 1 and at least one byte sent since the last fill/idle/check, 16 check bits follow: check value bit 0 first up to bit 15 (low byte first). The update per data bit b (bit 0 first) is fb = b ^ c[15], c = c << 1, and if fb then c ^= P. P is 0x8005 when crc16_sel is 1 and 0x1021 when it is 0. The start value is 0xFFFF when preset_ones is 1 and 0x0000 otherwise. The value is sent inverted when crc16_sel is 0.
- R5: A byte takes part in the check value only if tx_crc_en is 1 in the clock in which it moves from the buffer into the shift register.
- R6: At underrun with no check value due (tx_crc_en 0, or no byte since the last fill), fill characters are sent repeatedly. The fill character is sync_char when flag_mode is 0 and 0x7E when flag_mode is 1.
- R7: Clearing tx_enable during a data or fill character lets that character finish; ser_out is then 1.
- R8: Clearing tx_enable during the check value drops its remaining bits at the next bit tick. That tick starts one full fill character, after which ser_out is 1.
- R9: A write strobe while the buffer is full is ignored. The stored byte is the one sent.
- R10: With async_auto 0, rts_n equals the inverse of rts_bit one clock later.
- R11: With async_auto 1, underrun leaves ser_out at 1 (no check value, no fill). After rts_bit is cleared, rts_n stays 0 until the shifter is idle with the buffer empty, and becomes 1 in the clock after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | One-clock pulse per serial bit time |
| tx_enable | input | 1 | Transmitter on |
| crc16_sel | input | 1 | 1: polynomial 0x8005, 0: polynomial 0x1021 (sent inverted) |
| preset_ones | input | 1 | Check start value all ones (1) or all zeros (0) |
| tx_crc_en | input | 1 | Include loaded bytes / append check value at underrun |
| rts_bit | input | 1 | Request-to-send control bit |
| async_auto | input | 1 | Asynchronous mode with automatic request-to-send release |
| flag_mode | input | 1 | Bit-synchronous fill with flag 0x7E |
| sync_char | input | 8 | Fill character for character-synchronous mode |
| wr_stb | input | 1 | Buffer write strobe |
| wr_data | input | 8 | Buffer write data |
| ser_out | output | 1 | Serial data |
| rts_n | output | 1 | Request to send, active low |
| buf_empty | output | 1 | Holding buffer can accept a byte |

## Verification
A corrupted check register or a wrong polynomial tap shows at ser_out within 16 bit ticks of the first underrun. It appears as one or more wrong check bits, so every sweep point compares the whole check field bit by bit. A phase register stuck in the wrong state shows as a missing or extra fill character, or as the line not returning to 1, within one character time of the triggering event. A bit-count error shifts every following bit, so the data field comparison catches it at once. A request-to-send state that releases too early shows in the very clock after rts_bit is cleared, while a byte is still queued.

// File: rtl/sstx_pkg.sv
// Shared types for the synchronous serial transmitter.
// Assumes one character is CHAR_W bits and the check value fits the shifter.
package sstx_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_CRC  = 2'd2,
        PH_FILL = 2'd3
    } tx_phase_e;
endpackage

// File: rtl/sstx_hold_buf.sv
// One-entry holding buffer. A write is accepted only while empty; a take
// empties it. Assumes take is raised only while full.
module sstx_hold_buf #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [CHAR_W-1:0] data
);
    // Fill on write when empty, drain on take; writes while full are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_stb && !full) begin
            full <= 1'b1;
            data <= wr_data;
        end
    end
endmodule

// File: rtl/sstx_crc_byte.sv
// Combinational update of a CRC_W-bit check value by one character,
// bit 0 of the character first, with a register shifting towards its MSB.
// One of two polynomials is picked at run time.
module sstx_crc_byte #(
    parameter int                CRC_W  = 16,
    parameter int                CHAR_W = 8,
    parameter logic [CRC_W-1:0]  POLY_A = 16'h8005,
    parameter logic [CRC_W-1:0]  POLY_B = 16'h1021
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [CHAR_W-1:0] char_in,
    input  logic              sel_a,
    output logic [CRC_W-1:0]  crc_out
);
    logic [CRC_W-1:0] poly;
    logic [CRC_W-1:0] stage [0:CHAR_W];

    // Pick the polynomial.
    assign poly     = sel_a ? POLY_A : POLY_B;
    assign stage[0] = crc_in;

    // One stage per character bit, least significant first.
    for (genvar g = 0; g < CHAR_W; g++) begin : g_bit
        logic fb;
        assign fb           = char_in[g] ^ stage[g][CRC_W-1];
        assign stage[g+1]   = {stage[g][CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    end

    assign crc_out = stage[CHAR_W];
endmodule

// File: rtl/sstx_shifter.sv
// Character sequencer and shift register. At every bit tick it either sends
// the next bit of the current character or, at a character boundary, picks
// the next one: data from the buffer, the check value, a fill character, or
// an idle line. Disabling during the check value swaps in a fill character.
// Assumes CRC_W >= CHAR_W.
module sstx_shifter
    import sstx_pkg::*;
#(
    parameter int               CHAR_W    = 8,
    parameter int               CRC_W     = 16,
    parameter logic [CHAR_W-1:0] FLAG_CHAR = 8'h7E,
    parameter logic [CRC_W-1:0] POLY_A    = 16'h8005,
    parameter logic [CRC_W-1:0] POLY_B    = 16'h1021
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              tx_enable,
    input  logic              crc16_sel,
    input  logic              preset_ones,
    input  logic              tx_crc_en,
    input  logic              async_auto,
    input  logic              flag_mode,
    input  logic [CHAR_W-1:0] sync_char,
    input  logic              buf_full,
    input  logic [CHAR_W-1:0] buf_data,
    output logic              take,
    output logic              ser_out,
    output tx_phase_e         phase
);
    localparam int SH_W  = CRC_W;
    localparam int CNT_W = $clog2(CRC_W + 1);

    tx_phase_e        phase_q;
    logic [SH_W-1:0]  shreg_q;
    logic [CNT_W-1:0] left_q;
    logic [CRC_W-1:0] crc_q;
    logic             pending_q;
    logic             ser_q;

    logic [CRC_W-1:0]  preset_val;
    logic [CRC_W-1:0]  crc_base;
    logic [CRC_W-1:0]  crc_upd;
    logic [CRC_W-1:0]  crc_tx;
    logic [CHAR_W-1:0] fill_char;
    logic              boundary;
    logic              abandon;

    // Start value of the check register for a new frame.
    assign preset_val = preset_ones ? '1 : '0;
    // A frame continues only while data is being sent back to back.
    assign crc_base   = (phase_q == PH_DATA) ? crc_q : preset_val;
    // Bit-synchronous polynomial is sent inverted.
    assign crc_tx     = crc16_sel ? crc_q : ~crc_q;
    // Fill character by framing mode.
    assign fill_char  = flag_mode ? FLAG_CHAR : sync_char;
    // Character boundary and check-value abandon conditions.
    assign boundary   = bit_en && (left_q == '0);
    assign abandon    = bit_en && (phase_q == PH_CRC) && (left_q != '0) && !tx_enable;
    // Buffer handed over only at a boundary while enabled.
    assign take       = boundary && tx_enable && buf_full;

    sstx_crc_byte #(
        .CRC_W (CRC_W),
        .CHAR_W(CHAR_W),
        .POLY_A(POLY_A),
        .POLY_B(POLY_B)
    ) u_crc (
        .crc_in (crc_base),
        .char_in(buf_data),
        .sel_a  (crc16_sel),
        .crc_out(crc_upd)
    );

    // Sequencer: one serial bit per tick, next character chosen at boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            shreg_q   <= '0;
            left_q    <= '0;
            crc_q     <= '0;
            pending_q <= 1'b0;
            ser_q     <= 1'b1;
        end else if (abandon) begin
            phase_q   <= PH_FILL;
            ser_q     <= fill_char[0];
            shreg_q   <= SH_W'(fill_char) >> 1;
            left_q    <= CNT_W'(CHAR_W - 1);
            pending_q <= 1'b0;
        end else if (boundary) begin
            if (!tx_enable) begin
                phase_q   <= PH_IDLE;
                ser_q     <= 1'b1;
                pending_q <= 1'b0;
            end else if (buf_full) begin
                phase_q   <= PH_DATA;
                ser_q     <= buf_data[0];
                shreg_q   <= SH_W'(buf_data) >> 1;
                left_q    <= CNT_W'(CHAR_W - 1);
                crc_q     <= tx_crc_en ? crc_upd : crc_base;
                pending_q <= 1'b1;
            end else if (async_auto) begin
                phase_q   <= PH_IDLE;
                ser_q     <= 1'b1;
                pending_q <= 1'b0;
            end else if (pending_q && tx_crc_en) begin
                phase_q   <= PH_CRC;
                ser_q     <= crc_tx[0];
                shreg_q   <= crc_tx >> 1;
                left_q    <= CNT_W'(CRC_W - 1);
                pending_q <= 1'b0;
            end else begin
                phase_q   <= PH_FILL;
                ser_q     <= fill_char[0];
                shreg_q   <= SH_W'(fill_char) >> 1;
                left_q    <= CNT_W'(CHAR_W - 1);
                pending_q <= 1'b0;
            end
        end else if (bit_en) begin
            ser_q   <= shreg_q[0];
            shreg_q <= shreg_q >> 1;
            left_q  <= left_q - CNT_W'(1);
        end
    end

    assign ser_out = ser_q;
    assign phase   = phase_q;
endmodule

// File: rtl/sstx_rts_ctl.sv
// Request-to-send driver. Follows the control bit one clock later, or in
// asynchronous auto-enable mode holds the request until the shifter is idle
// and the buffer empty.
module sstx_rts_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic rts_bit,
    input  logic async_auto,
    input  logic line_idle,
    input  logic buf_empty,
    output logic rts_n
);
    // Assert on request; release at once or after the last character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rts_n <= 1'b1;
        end else if (rts_bit) begin
            rts_n <= 1'b0;
        end else if (!async_auto || (line_idle && buf_empty)) begin
            rts_n <= 1'b1;
        end
    end
endmodule

// File: rtl/sync_ser_tx.sv
// Top of the synchronous serial transmitter: holding buffer, sequencer with
// check generator, and request-to-send driver. Assumes bit_en is a single
// clock pulse per serial bit time and all control inputs are synchronous.
module sync_ser_tx
    import sstx_pkg::*;
#(
    parameter int                CHAR_W    = 8,
    parameter int                CRC_W     = 16,
    parameter logic [CHAR_W-1:0] FLAG_CHAR = 8'h7E,
    parameter logic [CRC_W-1:0]  POLY_A    = 16'h8005,
    parameter logic [CRC_W-1:0]  POLY_B    = 16'h1021
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              tx_enable,
    input  logic              crc16_sel,
    input  logic              preset_ones,
    input  logic              tx_crc_en,
    input  logic              rts_bit,
    input  logic              async_auto,
    input  logic              flag_mode,
    input  logic [CHAR_W-1:0] sync_char,
    input  logic              wr_stb,
    input  logic [CHAR_W-1:0] wr_data,
    output logic              ser_out,
    output logic              rts_n,
    output logic              buf_empty
);
    logic              buf_full;
    logic [CHAR_W-1:0] buf_data;
    logic              take;
    tx_phase_e         tx_phase;

    sstx_hold_buf #(.CHAR_W(CHAR_W)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (wr_stb),
        .wr_data(wr_data),
        .take   (take),
        .full   (buf_full),
        .data   (buf_data)
    );

    sstx_shifter #(
        .CHAR_W   (CHAR_W),
        .CRC_W    (CRC_W),
        .FLAG_CHAR(FLAG_CHAR),
        .POLY_A   (POLY_A),
        .POLY_B   (POLY_B)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .tx_enable  (tx_enable),
        .crc16_sel  (crc16_sel),
        .preset_ones(preset_ones),
        .tx_crc_en  (tx_crc_en),
        .async_auto (async_auto),
        .flag_mode  (flag_mode),
        .sync_char  (sync_char),
        .buf_full   (buf_full),
        .buf_data   (buf_data),
        .take       (take),
        .ser_out    (ser_out),
        .phase      (tx_phase)
    );

    sstx_rts_ctl u_rts (
        .clk       (clk),
        .rst_n     (rst_n),
        .rts_bit   (rts_bit),
        .async_auto(async_auto),
        .line_idle (tx_phase == PH_IDLE),
        .buf_empty (!buf_full),
        .rts_n     (rts_n)
    );

    assign buf_empty = !buf_full;
endmodule

// File: rtl/sync_ser_tx_chk.sv
// Property checker for sync_ser_tx, bound to every instance of the top.
module sync_ser_tx_chk
    import sstx_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      bit_en,
    input logic      tx_enable,
    input logic      async_auto,
    input logic      rts_bit,
    input logic      ser_out,
    input logic      rts_n,
    input logic      buf_empty,
    input tx_phase_e phase
);
    // R3
    hold_when_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(ser_out));

    // R2
    no_drain_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_enable && !buf_empty) |=> !buf_empty);

    // R9
    keep_until_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_empty && !bit_en) |=> !buf_empty);

    // R8
    crc_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CRC && bit_en && !tx_enable) |=> phase != PH_CRC);

    // R10
    rts_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !async_auto |=> rts_n == !$past(rts_bit));

    // R11
    rts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (async_auto && !rts_n && phase != PH_IDLE) |=> !rts_n);
endmodule

bind sync_ser_tx sync_ser_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .tx_enable (tx_enable),
    .async_auto(async_auto),
    .rts_bit   (rts_bit),
    .ser_out   (ser_out),
    .rts_n     (rts_n),
    .buf_empty (buf_empty),
    .phase     (tx_phase)
);

// File: tb/tb_sync_ser_tx.sv
module tb_sync_ser_tx;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n, bit_en, tx_enable, crc16_sel, preset_ones, tx_crc_en;
    logic       rts_bit, async_auto, flag_mode, wr_stb;
    logic [7:0] sync_char, wr_data;
    logic       ser_out, rts_n, buf_empty;

    sync_ser_tx dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_enable(tx_enable),
        .crc16_sel(crc16_sel), .preset_ones(preset_ones), .tx_crc_en(tx_crc_en),
        .rts_bit(rts_bit), .async_auto(async_auto), .flag_mode(flag_mode),
        .sync_char(sync_char), .wr_stb(wr_stb), .wr_data(wr_data),
        .ser_out(ser_out), .rts_n(rts_n), .buf_empty(buf_empty)
    );

    int total = 0;
    int bad   = 0;

    logic       got     [0:511];
    logic       got_rts [0:511];
    logic       exp_b   [0:511];
    int         elen;
    logic [7:0] dat     [0:7];
    logic       en_at   [0:15];
    int         nbytes, dis_at, rts_clr_at, div, unstable;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic push_bits(input logic [15:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            exp_b[elen] = v[i];
            elen++;
        end
    endtask

    task automatic push_ones(input int n);
        for (int i = 0; i < n; i++) begin
            exp_b[elen] = 1'b1;
            elen++;
        end
    endtask

    // Compare captured stream against expected bits in [lo, hi).
    task automatic cmp(input string req, input string what, input int lo, input int hi);
        int first = -1;
        for (int i = lo; i < hi; i++)
            if (got[i] !== exp_b[i] && first < 0) first = i;
        if (first < 0) check(1'b1, req, what, 0, 0);
        else check(1'b0, req, {what, " first bad bit index/value"},
                   first * 16 + int'(got[first]), first * 16 + int'(exp_b[first]));
    endtask

    function automatic logic [15:0] crc_of(input bit sel16, input bit ones, input int n);
        logic [15:0] c = ones ? 16'hFFFF : 16'h0000;
        for (int k = 0; k < n; k++) begin
            if (en_at[k]) begin
                for (int i = 0; i < 8; i++) begin
                    logic fb = dat[k][i] ^ c[15];
                    c = {c[14:0], 1'b0};
                    if (fb) c = c ^ (sel16 ? 16'h8005 : 16'h1021);
                end
            end
        end
        return sel16 ? c : ~c;
    endfunction

    task automatic defaults();
        for (int k = 0; k < 16; k++) en_at[k] = 1'b1;
        dis_at = -1; rts_clr_at = -1; div = 1; elen = 0;
    endtask

    // Enable the transmitter and capture ntick bits, feeding the buffer.
    task automatic run(input int ntick);
        int idx = 0;
        if (nbytes > 0) begin
            @(negedge clk); wr_data = dat[0]; wr_stb = 1'b1;
            @(negedge clk); wr_stb = 1'b0;
            idx = 1;
        end
        unstable = 0;
        for (int t = 0; t < ntick; t++) begin
            bit_en = 1'b1;
            if (t == 0) tx_enable = 1'b1;
            if (t % 8 == 0 && t / 8 < 16) tx_crc_en = en_at[t / 8];
            if (t == dis_at) tx_enable = 1'b0;
            if (t == rts_clr_at) rts_bit = 1'b0;
            if (buf_empty && idx < nbytes) begin
                wr_data = dat[idx]; wr_stb = 1'b1; idx++;
            end
            @(posedge clk); @(negedge clk);
            got[t] = ser_out; got_rts[t] = rts_n;
            bit_en = 1'b0; wr_stb = 1'b0;
            for (int d = 1; d < div; d++) begin
                @(posedge clk); @(negedge clk);
                if (ser_out !== got[t]) unstable++;
            end
        end
        tx_enable = 1'b0; bit_en = 1'b1;
        repeat (40) @(negedge clk);
        bit_en = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bit_en = 1'b0; tx_enable = 1'b0; crc16_sel = 1'b0;
        preset_ones = 1'b0; tx_crc_en = 1'b0; rts_bit = 1'b0; async_auto = 1'b0;
        flag_mode = 1'b0; sync_char = 8'h16; wr_stb = 1'b0; wr_data = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ser_out === 1'b1, "R1", "ser_out in reset", ser_out, 1);
        check(rts_n === 1'b1, "R1", "rts_n in reset", rts_n, 1);
        check(buf_empty === 1'b1, "R1", "buf_empty in reset", buf_empty, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 and R9: disabled line stays 1, byte kept, second write dropped
        begin
            int ones = 0;
            bit_en = 1'b1;
            wr_data = 8'hA5; wr_stb = 1'b1; @(negedge clk);
            wr_data = 8'h3C; @(negedge clk); wr_stb = 1'b0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (ser_out === 1'b1) ones++;
            end
            check(ones == 20, "R2", "line high while disabled", ones, 20);
            check(buf_empty === 1'b0, "R2", "buffer kept while disabled", buf_empty, 0);
            bit_en = 1'b0;
        end
        defaults(); nbytes = 0; flag_mode = 1'b1;
        for (int k = 0; k < 16; k++) en_at[k] = 1'b0;
        run(24);
        push_bits(16'h00A5, 8); push_bits(16'h007E, 8); push_bits(16'h007E, 8);
        cmp("R9", "first written byte sent, later write dropped", 0, 8);
        cmp("R6", "flag fill after byte", 8, 24);

        // R3/R4/R6 sweep: polynomial x preset x framing
        for (int cfg = 0; cfg < 8; cfg++) begin
            defaults();
            crc16_sel = cfg[0]; preset_ones = cfg[1]; flag_mode = cfg[2];
            sync_char = 8'h16 + 8'(cfg * 8);
            nbytes = 3;
            for (int k = 0; k < 3; k++) dat[k] = 8'(37 * k + 11 * cfg + 5);
            run(64);
            for (int k = 0; k < 3; k++) push_bits({8'h00, dat[k]}, 8);
            push_bits(crc_of(crc16_sel, preset_ones, 3), 16);
            push_bits(flag_mode ? 16'h007E : {8'h00, sync_char}, 8);
            push_bits(flag_mode ? 16'h007E : {8'h00, sync_char}, 8);
            cmp("R3", "data bits LSB first", 0, 24);
            cmp("R4", "check value bits", 24, 40);
            cmp("R6", "fill after check value", 40, 56);
        end

        // R5: inclusion decided at load time
        for (int v = 0; v < 2; v++) begin
            defaults(); crc16_sel = 1'b1; preset_ones = 1'b1; flag_mode = 1'b1;
            nbytes = 4;
            for (int k = 0; k < 4; k++) dat[k] = 8'(8'h5A ^ (k * 8'h23));
            if (v == 0) en_at[1] = 1'b0; else en_at[0] = 1'b0;
            run(56);
            for (int k = 0; k < 4; k++) push_bits({8'h00, dat[k]}, 8);
            push_bits(crc_of(1'b1, 1'b1, 4), 16);
            cmp("R5", "check value skips excluded byte", 32, 48);
        end

        // R6: underrun without check enable gives sync fill at once
        defaults(); crc16_sel = 1'b0; flag_mode = 1'b0; sync_char = 8'h9A;
        nbytes = 2; dat[0] = 8'hC3; dat[1] = 8'h01; en_at[2] = 1'b0;
        run(40);
        push_bits(16'h00C3, 8); push_bits(16'h0001, 8);
        push_bits(16'h009A, 8); push_bits(16'h009A, 8); push_bits(16'h009A, 8);
        cmp("R6", "sync fill right after data", 0, 40);

        // R3: slowed bit clock, output held between ticks
        defaults(); crc16_sel = 1'b1; preset_ones = 1'b0; flag_mode = 1'b1;
        nbytes = 2; dat[0] = 8'h81; dat[1] = 8'h6E; div = 3;
        run(40);
        push_bits(16'h0081, 8); push_bits(16'h006E, 8);
        push_bits(crc_of(1'b1, 1'b0, 2), 16); push_bits(16'h007E, 8);
        check(unstable == 0, "R3", "ser_out changed without tick", unstable, 0);
        cmp("R3", "stream with slow bit clock", 0, 40);

        // R7: disable mid data character
        defaults(); flag_mode = 1'b1; nbytes = 1; dat[0] = 8'h4D; dis_at = 3;
        run(20);
        push_bits(16'h004D, 8); push_ones(12);
        cmp("R7", "data char finished then idle", 0, 20);

        // R7: disable mid fill character
        defaults(); flag_mode = 1'b0; sync_char = 8'h2C; nbytes = 1; dat[0] = 8'hF0;
        en_at[1] = 1'b0; dis_at = 10;
        run(28);
        push_bits(16'h00F0, 8); push_bits(16'h002C, 8); push_ones(12);
        cmp("R7", "fill char finished then idle", 0, 28);

        // R8: disable during check value
        defaults(); crc16_sel = 1'b0; preset_ones = 1'b1; flag_mode = 1'b1;
        nbytes = 2; dat[0] = 8'h12; dat[1] = 8'hE7; dis_at = 21;
        run(40);
        push_bits(16'h0012, 8); push_bits(16'h00E7, 8);
        push_bits(crc_of(1'b0, 1'b1, 2), 5); push_bits(16'h007E, 8); push_ones(11);
        cmp("R8", "check cut, one flag, then idle", 0, 40);

        // R10: direct request-to-send
        async_auto = 1'b0;
        @(negedge clk); rts_bit = 1'b1; @(negedge clk);
        check(rts_n === 1'b0, "R10", "rts_n after set", rts_n, 0);
        rts_bit = 1'b0; @(negedge clk);
        check(rts_n === 1'b1, "R10", "rts_n after clear", rts_n, 1);

        // R11: auto-enable release waits for the last character
        defaults(); async_auto = 1'b1; rts_bit = 1'b1; @(negedge clk);
        nbytes = 2; dat[0] = 8'h3B; dat[1] = 8'hD4; rts_clr_at = 2;
        run(24);
        push_bits(16'h003B, 8); push_bits(16'h00D4, 8); push_ones(8);
        cmp("R11", "async underrun idles line", 0, 24);
        begin
            int early = 0;
            for (int t = 2; t <= 16; t++) if (got_rts[t] !== 1'b0) early++;
            check(early == 0, "R11", "rts_n released early", early, 0);
            check(got_rts[17] === 1'b1, "R11", "rts_n released after idle", got_rts[17], 1);
        end
        async_auto = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule